// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Generator

This block sits on a 24-bit processor bus and turns each address-strobed access into one of two active-low external memory selects, an active-low select for a relocatable 4 KB internal window, and an active-low data-acknowledge. Each external select has its own base address, address mask, enable bit and acknowledge delay of 0 to 7 wait states. Software sets these through 16-bit registers.

Two registers have fixed addresses and can be reached at any time: a window base register at $0F2 and a general control register at $0F4. The chip-select registers live inside the relocatable window. That window stays undecoded until the window base register has been written.

Out of reset, select 0 covers an 8 KB boot area at address 0 with six wait states, and select 1 is off. Boot code can therefore fetch from ROM, place the internal window, widen the ROM select, and then move the RAM select under the low addresses.

Top module: `csu_top`

## Requirements
- R1: After reset, select 0 is enabled with base 0 and an 8 KB window, so addresses $000000 to $001FFF select it and $002000 does not. Its acknowledge delay is 6 wait states. Select 1 is disabled and never asserts.
- R2: The window base register at $0F2 and the control register at $0F4 can be written and read at any time. An access to either one asserts no external select and no window select, and it is acknowledged with 0 wait states.
- R3: Until the window base register is written, no address asserts the window select. Once a value V is written, addresses whose bits 23:12 equal V[11:0] assert the window select with 0 wait states, and no external select asserts for them. Writing $0700 places the window at $700000 to $700FFF.
- R4: Chip-select n has two registers in the window: a base register at window offset $100+4n and an option register at offset $102+4n. In the base register, bit 15 is the enable and bits 10:0 give address bits 23:13. In the option register, bits 10:0 are the mask for address bits 23:13 and bits 13:11 are the wait count. Reads return the full 16-bit value last written. The defaults are base0=$8000, base1=$0000 and option=$37FF for both selects.
- R5: An enabled select matches when address bits 23:13 ANDed with its mask equal its base field ANDed with the same mask. Writing mask 11111100000b with base 0 widens select 0 to 256 KB.
- R6: When both selects match, only select 0 asserts. At most one external select is ever asserted.
- R7: Selects become active on the first clock after the strobe is sampled low. The acknowledge becomes active W clocks later, where W is the wait count of the selected target. An access that hits nothing is never acknowledged.
- R8: On the first clock edge that samples the strobe high, the selects, the window select and the acknowledge all negate. Write data held one clock past the strobe therefore stays valid after the select has negated.
- R9: A synchronous reset returns every register, the window-valid state and all outputs to their defaults.
- R10: Read cycles never change a register, whatever value is on the write-data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 24 | Bus byte address |
| asN | input | 1 | Address strobe, active low |
| rdWrN | input | 1 | 1 = read, 0 = write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Register read data (0 when no register is addressed) |
| csN | output | 2 | External chip selects, active low |
| intSelN | output | 1 | Internal window select, active low |
| dtackN | output | 1 | Data acknowledge, active low |

## Verification
The hardest situation to reach is an address that lies in both external windows at once while the fixed registers still overlap the boot window. This only arises after a specific order of writes: place the internal window, reprogram select 0, then move select 1 on top of it. The directed part of the stimulus replays that boot-time ROM/RAM swap and probes every region after each step. The random part then rewrites base, mask, enable and wait fields and probes addresses drawn near the fixed registers, inside the window and across the whole space. Each result is compared with a bench model of the register state.

// File: rtl/csu_pkg.sv
package csu_pkg;
  parameter int ADDR_W   = 24;
  parameter int DATA_W   = 16;
  parameter int NUM_CS   = 2;
  parameter int WAIT_W   = 3;
  parameter int MASK_W   = 11;
  parameter int BLK_BITS = 12;

  localparam int GRAN_BITS = ADDR_W - MASK_W;   // 8 KB select granularity
  localparam int BLK_TAG_W = ADDR_W - BLK_BITS;
  localparam int EN_BIT    = DATA_W - 1;
  localparam int WAIT_LSB  = MASK_W;

  localparam logic [ADDR_W-1:0]   BAR_ADDR  = ADDR_W'(24'h0000F2);
  localparam logic [ADDR_W-1:0]   SCR_ADDR  = ADDR_W'(24'h0000F4);
  localparam logic [BLK_BITS-1:0] CSREG_OFS = BLK_BITS'(12'h100);
  localparam logic [WAIT_W-1:0]   BOOT_WAIT = WAIT_W'(6);

  localparam logic [DATA_W-1:0] BASE0_RST = DATA_W'(1) << EN_BIT;
  localparam logic [DATA_W-1:0] OPT_RST   =
    (DATA_W'(BOOT_WAIT) << WAIT_LSB) | DATA_W'((1 << MASK_W) - 1);

  typedef struct packed {
    logic regWrite;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [NUM_CS-1:0] extSel;
    logic              intSel;
    logic              regHit;
    logic              anyHit;
    logic [WAIT_W-1:0] waitCnt;
  } decode_t;
endpackage

// File: rtl/csu_datapath.sv
module csu_datapath
  import csu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobes_t      strb,
  output decode_t           dec,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] barQ, scrQ;
  logic              barValid;
  logic [DATA_W-1:0] baseQ [NUM_CS];
  logic [DATA_W-1:0] optQ  [NUM_CS];

  logic                fixedBar, fixedScr, fixedHit, blockHit;
  logic [BLK_BITS-1:0] offset;
  logic [NUM_CS-1:0]   rawMatch, baseHit, optHit;

  assign fixedBar = (addr == BAR_ADDR);
  assign fixedScr = (addr == SCR_ADDR);
  assign fixedHit = fixedBar || fixedScr;
  assign offset   = addr[BLK_BITS-1:0];
  // fixed registers win over the relocatable window
  assign blockHit = barValid && !fixedHit &&
                    (addr[ADDR_W-1:BLK_BITS] == barQ[BLK_TAG_W-1:0]);

  for (genvar g = 0; g < NUM_CS; g++) begin : gSel
    localparam logic [BLK_BITS-1:0] BaseOfs = CSREG_OFS + BLK_BITS'(4 * g);
    localparam logic [BLK_BITS-1:0] OptOfs  = BaseOfs + BLK_BITS'(2);
    assign baseHit[g]  = blockHit && (offset == BaseOfs);
    assign optHit[g]   = blockHit && (offset == OptOfs);
    assign rawMatch[g] = baseQ[g][EN_BIT] &&
      (((addr[ADDR_W-1:GRAN_BITS] ^ baseQ[g][MASK_W-1:0]) &
        optQ[g][MASK_W-1:0]) == '0);
  end

  // lowest-numbered matching select wins; internal hits suppress all
  always_comb begin
    dec.extSel  = '0;
    dec.waitCnt = '0;
    if (!fixedHit && !blockHit) begin
      for (int i = NUM_CS - 1; i >= 0; i--) begin
        if (rawMatch[i]) begin
          dec.extSel  = NUM_CS'(1) << i;
          dec.waitCnt = optQ[i][WAIT_LSB +: WAIT_W];
        end
      end
    end
    dec.intSel = blockHit;
    dec.regHit = fixedHit || blockHit;
    dec.anyHit = fixedHit || blockHit || (|rawMatch);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      barQ     <= '0;
      scrQ     <= '0;
      barValid <= 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
        baseQ[i] <= (i == 0) ? BASE0_RST : '0;
        optQ[i]  <= OPT_RST;
      end
    end else if (strb.regWrite) begin
      if (fixedBar) begin
        barQ     <= wrData;
        barValid <= 1'b1;
      end
      if (fixedScr) scrQ <= wrData;
      for (int i = 0; i < NUM_CS; i++) begin
        if (baseHit[i]) baseQ[i] <= wrData;
        if (optHit[i])  optQ[i]  <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (fixedBar) rdData = barQ;
    if (fixedScr) rdData = scrQ;
    for (int i = 0; i < NUM_CS; i++) begin
      if (baseHit[i]) rdData = baseQ[i];
      if (optHit[i])  rdData = optQ[i];
    end
  end
endmodule

// File: rtl/csu_ctrl.sv
module csu_ctrl
  import csu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              asN,
  input  logic              rdWrN,
  input  decode_t           dec,
  output ctrlStrobes_t      strb,
  output logic [NUM_CS-1:0] csN,
  output logic              intSelN,
  output logic              dtackN
);
  localparam logic [WAIT_W-1:0] CntMax = '1;

  logic              inCycle;
  logic [WAIT_W-1:0] cnt;

  // one register write per bus cycle, on its first sampled edge
  always_comb strb.regWrite = !asN && !inCycle && !rdWrN && dec.regHit;

  always_ff @(posedge clk) begin
    if (rst || asN) begin
      inCycle <= 1'b0;
      cnt     <= '0;
      csN     <= '1;
      intSelN <= 1'b1;
      dtackN  <= 1'b1;
    end else begin
      inCycle <= 1'b1;
      csN     <= ~dec.extSel;
      intSelN <= ~dec.intSel;
      if (cnt != CntMax) cnt <= cnt + 1'b1;
      dtackN  <= ~(dec.anyHit && (cnt >= dec.waitCnt));
    end
  end
endmodule

// File: rtl/csu_top.sv
module csu_top
  import csu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              asN,
  input  logic              rdWrN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CS-1:0] csN,
  output logic              intSelN,
  output logic              dtackN
);
  ctrlStrobes_t strb;
  decode_t      dec;

  csu_datapath u_dp (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData),
    .strb(strb), .dec(dec), .rdData(rdData)
  );

  csu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .asN(asN), .rdWrN(rdWrN), .dec(dec),
    .strb(strb), .csN(csN), .intSelN(intSelN), .dtackN(dtackN)
  );
endmodule

// File: rtl/csu_checker.sv
module csu_checker
  import csu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              asN,
  input logic [NUM_CS-1:0] csN,
  input logic              intSelN,
  input logic              dtackN
);
  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~csN));

  p_int_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !intSelN |-> (csN == '1));

  p_fixed_nosel_r2: assert property (@(posedge clk) disable iff (rst)
    (!asN && (addr == BAR_ADDR || addr == SCR_ADDR)) |=> (csN == '1 && intSelN));

  p_negate_r8: assert property (@(posedge clk) disable iff (rst)
    asN |=> (csN == '1 && intSelN && dtackN));

  p_ack_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !dtackN |-> $past(!asN));
endmodule

bind csu_top csu_checker u_chk (
  .clk(clk), .rst(rst), .addr(addr), .asN(asN),
  .csN(csN), .intSelN(intSelN), .dtackN(dtackN)
);

// File: tb/csu_top_test.sv
module csu_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] addr = '0;
  logic        asN = 1'b1;
  logic        rdWrN = 1'b1;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  csN;
  logic        intSelN, dtackN;

  int checks = 0;
  int errors = 0;

  // bench model of register state
  logic [15:0] mBar, mScr;
  logic        mBarValid;
  logic [15:0] mBase [2];
  logic [15:0] mOpt  [2];

  typedef struct packed {
    logic [1:0] cs;
    logic       intN;
    logic [3:0] waits;   // 15 = never acknowledged
  } exp_t;

  always #2 clk = ~clk;   // 250 MHz

  csu_top uut (
    .clk(clk), .rst(rst), .addr(addr), .asN(asN), .rdWrN(rdWrN),
    .wrData(wrData), .rdData(rdData), .csN(csN), .intSelN(intSelN),
    .dtackN(dtackN)
  );

  task automatic modelReset();
    mBar = '0; mScr = '0; mBarValid = 1'b0;
    mBase[0] = 16'h8000; mBase[1] = 16'h0000;
    mOpt[0] = 16'h37FF;  mOpt[1] = 16'h37FF;
  endtask

  function automatic logic inBlock(input logic [23:0] a);
    return mBarValid && a != 24'h0000F2 && a != 24'h0000F4 &&
           a[23:12] == mBar[11:0];
  endfunction

  function automatic exp_t expDecode(input logic [23:0] a);
    exp_t e;
    logic [1:0] m;
    for (int g = 0; g < 2; g++)
      m[g] = mBase[g][15] &&
             ((a[23:13] & mOpt[g][10:0]) == (mBase[g][10:0] & mOpt[g][10:0]));
    e = '{cs: 2'b11, intN: 1'b1, waits: 4'd15};
    if (a == 24'h0000F2 || a == 24'h0000F4) e.waits = 0;
    else if (inBlock(a)) begin e.intN = 1'b0; e.waits = 0; end
    else if (m[0]) begin e.cs = 2'b10; e.waits = {1'b0, mOpt[0][13:11]}; end
    else if (m[1]) begin e.cs = 2'b01; e.waits = {1'b0, mOpt[1][13:11]}; end
    return e;
  endfunction

  function automatic logic [15:0] expRead(input logic [23:0] a);
    if (a == 24'h0000F2) return mBar;
    if (a == 24'h0000F4) return mScr;
    if (inBlock(a)) begin
      for (int g = 0; g < 2; g++) begin
        if (a[11:0] == 12'h100 + 12'(4 * g)) return mBase[g];
        if (a[11:0] == 12'h102 + 12'(4 * g)) return mOpt[g];
      end
    end
    return 16'h0000;
  endfunction

  task automatic modelWrite(input logic [23:0] a, input logic [15:0] d);
    if (a == 24'h0000F2) begin mBar = d; mBarValid = 1'b1; end
    else if (a == 24'h0000F4) mScr = d;
    else if (inBlock(a)) begin
      for (int g = 0; g < 2; g++) begin
        if (a[11:0] == 12'h100 + 12'(4 * g)) mBase[g] = d;
        if (a[11:0] == 12'h102 + 12'(4 * g)) mOpt[g] = d;
      end
    end
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // one bus cycle; checks decode, wait count, read data and the negation
  task automatic busCycle(input logic [23:0] a, input logic wr,
                          input logic [15:0] d, input string req);
    exp_t e;
    logic [1:0] csSeen;
    logic intSeen;
    logic [15:0] rd, expRd;
    int waits;
    e = expDecode(a);
    expRd = expRead(a);
    @(negedge clk);
    addr = a; rdWrN = !wr; wrData = d; asN = 1'b0;
    waits = 15; csSeen = 2'b11; intSeen = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 0) begin csSeen = csN; intSeen = intSelN; end
      if (!dtackN) begin waits = i; break; end
    end
    rd = rdData;
    check(csSeen == e.cs, req, $sformatf("csN @%h", a), 32'(csSeen), 32'(e.cs));
    check(intSeen == e.intN, req, $sformatf("intSelN @%h", a), 32'(intSeen), 32'(e.intN));
    check(waits == int'(e.waits), req, $sformatf("waits @%h", a), 32'(waits), 32'(e.waits));
    if (!wr)
      check(rd == expRd, req, $sformatf("rdData @%h", a), 32'(rd), 32'(expRd));
    asN = 1'b1;                       // data still held one more clock
    @(negedge clk);
    check(csN == 2'b11 && intSelN && dtackN && wrData == d, "R8",
          "negate after strobe", {28'd0, csN, intSelN, dtackN}, 32'hF);
    if (wr) modelWrite(a, d);
    addr = 24'(($urandom));
    wrData = 16'($urandom);
  endtask

  task automatic probe(input logic [23:0] a, input string req);
    busCycle(a, 1'b0, 16'($urandom), req);
  endtask

  task automatic regWr(input logic [23:0] a, input logic [15:0] d, input string req);
    busCycle(a, 1'b1, d, req);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; asN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN == 2'b11 && intSelN && dtackN, "R9", "outputs in reset",
          {28'd0, csN, intSelN, dtackN}, 32'hF);
    rst = 1'b0;
    modelReset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    modelReset();
    doReset();

    // R1: boot window
    probe(24'h000000, "R1");
    probe(24'h001FFE, "R1");
    probe(24'h002000, "R1");
    probe(24'h400000, "R1");
    // R3: window not decoded yet
    probe(24'h700000, "R3");
    // R2: fixed registers before relocation
    probe(24'h0000F2, "R2");
    regWr(24'h0000F4, 16'hA5A5, "R2");
    probe(24'h0000F4, "R2");
    // R10: read with junk write data leaves register unchanged
    busCycle(24'h0000F4, 1'b0, 16'hFFFF, "R10");
    probe(24'h0000F4, "R10");
    // R3: place window at $700000
    regWr(24'h0000F2, 16'h0700, "R3");
    probe(24'h0000F2, "R3");
    probe(24'h700000, "R3");
    probe(24'h700FFE, "R3");
    probe(24'h701000, "R3");
    // R4: default register contents
    probe(24'h700100, "R4");
    probe(24'h700102, "R4");
    probe(24'h700104, "R4");
    probe(24'h700106, "R4");
    // R5: widen select 0 to 256 KB, 2 waits
    regWr(24'h700102, 16'h17E0, "R5");
    probe(24'h002000, "R5");
    probe(24'h03FFFE, "R5");
    probe(24'h040000, "R5");
    // R5: RAM select at $400000, 64 KB, 0 waits
    regWr(24'h700106, 16'h07F8, "R5");
    regWr(24'h700104, 16'h8200, "R5");
    probe(24'h400000, "R5");
    probe(24'h40FFFE, "R5");
    probe(24'h410000, "R5");
    // R6: RAM moved onto address 0, ROM still there -> select 0 wins
    regWr(24'h700104, 16'h8000, "R6");
    probe(24'h000100, "R6");
    // swap complete: ROM moved to $200000
    regWr(24'h700100, 16'h8100, "R6");
    probe(24'h000100, "R6");
    probe(24'h200000, "R5");
    probe(24'h0000F2, "R2");
    probe(24'h00FFFE, "R7");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int kind;
      logic [23:0] a;
      kind = int'($urandom % 6);
      case (kind)
        0: regWr(24'h700100 + 24'(4 * ($urandom % 2)),
                 {1'($urandom), 4'($urandom), 11'($urandom)}, "R4");
        1: regWr(24'h700102 + 24'(4 * ($urandom % 2)),
                 {2'($urandom), 3'($urandom), 11'($urandom)}, "R7");
        2: probe(24'h700100 + 24'(2 * ($urandom % 4)), "R4");
        3: begin
          a = {12'h700, 11'($urandom), 1'b0};
          probe(a, "R3");
        end
        4: probe(($urandom % 2) ? 24'h0000F2 : 24'h0000F4, "R2");
        default: begin
          a = 24'($urandom);
          if ($urandom % 2) a[23:20] = 4'h0;
          probe(a, "R5");
        end
      endcase
    end

    // R9: reset restores boot defaults
    doReset();
    probe(24'h000000, "R9");
    probe(24'h002000, "R9");
    probe(24'h0000F2, "R9");
    probe(24'h700000, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule